// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block sits beside the load/store stage of a 32-bit little-endian core and carries out every data access that touches less than, or straddles, a naturally aligned word. It forms the effective address from a base register and a signed 16-bit displacement. It always reads the aligned word that contains that address. It then either shapes the read word into a register result or merges register bytes into it and writes the word back.

Left and right partial-word loads combine the aligned memory word with the old destination value. A shift and a keep-mask are chosen for each byte offset. Byte and halfword loads pick a lane and extend it with sign or with zeros. Every store, whether partial or whole, is a read-modify-write of the aligned word. The store writes in the cycle after its read. One request is in flight at a time, and each request ends with a single `done` pulse.

Top module: `ldm_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to 32 bits, modulo 2^32. Every memory access uses that address with bits [1:0] cleared. Bits [1:0] form the byte offset k, where lane k is bits [8k+7:8k].
- R2: A request is taken when `req_valid` is high, `busy` is low and the code is legal. `mem_rd_en` is high in the following cycle. `done` is high for exactly one cycle, two cycles after the read cycle. `busy` is high from the read cycle through the `done` cycle.
- R3: Left load (code 0x2): for k = 0..3 the result is memory shifted left by 24, 16, 8 or 0 bits, ORed with the old register value ANDed with 0x00FFFFFF, 0x0000FFFF, 0x000000FF or 0.
- R4: Right load (code 0x6): for k = 0..3 the result is memory shifted right by 0, 8, 16 or 24 bits, ORed with the old register value ANDed with 0, 0xFF000000, 0xFFFF0000 or 0xFFFFFF00.
- R5: Left store (code 0xA): for k = 0..3 the written word is the register shifted right by 24, 16, 8 or 0 bits, ORed with the read word ANDed with 0xFFFFFF00, 0xFFFF0000, 0xFF000000 or 0.
- R6: Right store (code 0xE): for k = 0..3 the written word is the register shifted left by 0, 8, 16 or 24 bits, ORed with the read word ANDed with 0, 0x000000FF, 0x0000FFFF or 0x00FFFFFF.
- R7: Byte loads take lane k, and halfword loads take bits [16h+15:16h] with h = bit 1 of the address. Codes 0x0 (byte) and 0x1 (halfword) sign-extend the value. Codes 0x4 (byte) and 0x5 (halfword) zero-extend it.
- R8: Word load (code 0x3) returns the read word unchanged. Byte store (0x8) replaces lane k of the read word with register bits [7:0]. Halfword store (0x9) replaces halfword h with register bits [15:0]. Word store (0xB) writes the whole register value.
- R9: A load whose destination index is 0 still performs its read, but `wb_en` stays low on its `done` cycle. Any other load raises `wb_en` with `wb_idx` and `wb_data` on its `done` cycle.
- R10: A store issues exactly one read and then exactly one write, in the cycle right after the read. `mem_rd_en` and `mem_wr_en` are never high together, and a store never raises `wb_en`. A load never writes.
- R11: Codes 0x7, 0xC, 0xD and 0xF are ignored. They cause no memory access, no `busy` and no `done`.
- R12: A request presented while `busy` is high is ignored.
- R13: While `rst_n` is low, `busy`, `mem_rd_en`, `mem_wr_en`, `wb_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation code |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed displacement |
| req_rt_idx | input | 5 | Destination index for loads |
| req_rt_val | input | 32 | Old destination value for loads, source data for stores |
| busy | output | 1 | A request is in flight |
| mem_rd_en | output | 1 | Aligned read strobe |
| mem_wr_en | output | 1 | Aligned write strobe |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged write word |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_rd_en` |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| done | output | 1 | Request complete |

## Verification
The timing assertions assume the memory returns read data exactly one cycle after `mem_rd_en`, and that it commits a write on the edge that ends the `mem_wr_en` cycle. The bench's word array follows that timing, so every merge sees the word as it stood before the request. The assertions also assume `rst_n` stays low for at least one edge before the first request. The stimulus holds reset for three cycles. Random requests are issued only when `busy` is low, and random codes are drawn only from the legal set. Illegal codes and requests made while busy are covered by separate directed cases.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  typedef enum logic [3:0] {
    OP_LB  = 4'h0,
    OP_LH  = 4'h1,
    OP_LWL = 4'h2,
    OP_LW  = 4'h3,
    OP_LBU = 4'h4,
    OP_LHU = 4'h5,
    OP_LWR = 4'h6,
    OP_SB  = 4'h8,
    OP_SH  = 4'h9,
    OP_SWL = 4'hA,
    OP_SW  = 4'hB,
    OP_SWR = 4'hE
  } ldm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_MERGE  = 2'd2,
    ST_FINISH = 2'd3
  } ldm_state_e;

  function automatic logic op_is_legal(input logic [3:0] code);
    case (code)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6,
      4'h8, 4'h9, 4'hA, 4'hB, 4'hE: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_store(input logic [3:0] code);
    return code[3];
  endfunction

endpackage

// File: rtl/ldm_addr_gen.sv
module ldm_addr_gen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] eff_addr,
  output logic [DATA_W-1:0] aligned_addr,
  output logic [OFS_W-1:0]  offset
);

  function automatic logic [DATA_W-1:0] calc_ea(input logic [DATA_W-1:0] b,
                                                input logic [IMM_W-1:0]  d);
    return b + {{(DATA_W-IMM_W){d[IMM_W-1]}}, d};
  endfunction

  assign eff_addr     = calc_ea(base, imm);
  assign aligned_addr = {eff_addr[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
  assign offset       = eff_addr[OFS_W-1:0];

endmodule

// File: rtl/ldm_load_align.sv
module ldm_load_align import ldm_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  ldm_op_e           op,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] reg_old,
  output logic [DATA_W-1:0] result
);

  // upper lanes come from memory, the lowest (BYTES-1-k) lanes stay from the register
  function automatic logic [DATA_W-1:0] left_load(input logic [DATA_W-1:0] m,
                                                  input logic [DATA_W-1:0] r,
                                                  input logic [OFS_W-1:0]  k);
    int sh;
    logic [DATA_W-1:0] keep;
    sh   = 8 * (BYTES - 1 - int'(k));
    keep = ~({DATA_W{1'b1}} << sh);
    return (m << sh) | (r & keep);
  endfunction

  // lower lanes come from memory, the top k lanes stay from the register
  function automatic logic [DATA_W-1:0] right_load(input logic [DATA_W-1:0] m,
                                                   input logic [DATA_W-1:0] r,
                                                   input logic [OFS_W-1:0]  k);
    int sh;
    logic [DATA_W-1:0] keep;
    sh   = 8 * int'(k);
    keep = ~({DATA_W{1'b1}} >> sh);
    return (m >> sh) | (r & keep);
  endfunction

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] m,
                                           input logic [OFS_W-1:0]  k);
    return 8'(m >> (8 * int'(k)));
  endfunction

  function automatic logic [15:0] pick_half(input logic [DATA_W-1:0] m,
                                            input logic [OFS_W-1:0]  k);
    return 16'(m >> (16 * int'(k >> 1)));
  endfunction

  logic [7:0]  lane_b;
  logic [15:0] lane_h;

  assign lane_b = pick_byte(mem_word, offset);
  assign lane_h = pick_half(mem_word, offset);

  always_comb begin
    case (op)
      OP_LB:   result = {{(DATA_W-8){lane_b[7]}}, lane_b};
      OP_LBU:  result = {{(DATA_W-8){1'b0}}, lane_b};
      OP_LH:   result = {{(DATA_W-16){lane_h[15]}}, lane_h};
      OP_LHU:  result = {{(DATA_W-16){1'b0}}, lane_h};
      OP_LW:   result = mem_word;
      OP_LWL:  result = left_load(mem_word, reg_old, offset);
      OP_LWR:  result = right_load(mem_word, reg_old, offset);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/ldm_store_merge.sv
module ldm_store_merge import ldm_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  ldm_op_e           op,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] wdata
);

  function automatic logic [DATA_W-1:0] left_store(input logic [DATA_W-1:0] m,
                                                   input logic [DATA_W-1:0] r,
                                                   input logic [OFS_W-1:0]  k);
    int sh;
    logic [DATA_W-1:0] keep;
    sh   = 8 * (BYTES - 1 - int'(k));
    keep = ~({DATA_W{1'b1}} >> sh);
    return (r >> sh) | (m & keep);
  endfunction

  function automatic logic [DATA_W-1:0] right_store(input logic [DATA_W-1:0] m,
                                                    input logic [DATA_W-1:0] r,
                                                    input logic [OFS_W-1:0]  k);
    int sh;
    logic [DATA_W-1:0] keep;
    sh   = 8 * int'(k);
    keep = ~({DATA_W{1'b1}} << sh);
    return (r << sh) | (m & keep);
  endfunction

  logic [BYTES-1:0]  lane_en;
  logic [DATA_W-1:0] lane_src;
  logic [DATA_W-1:0] lane_word;

  always_comb begin
    case (op)
      OP_SB: begin
        lane_en  = BYTES'(1) << int'(offset);
        lane_src = {BYTES{reg_val[7:0]}};
      end
      OP_SH: begin
        lane_en  = BYTES'(3) << (2 * int'(offset >> 1));
        lane_src = {(BYTES/2){reg_val[15:0]}};
      end
      OP_SW: begin
        lane_en  = '1;
        lane_src = reg_val;
      end
      default: begin
        lane_en  = '0;
        lane_src = reg_val;
      end
    endcase
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_word[8*g +: 8] = lane_en[g] ? lane_src[8*g +: 8] : mem_word[8*g +: 8];
  end

  always_comb begin
    case (op)
      OP_SWL:  wdata = left_store(mem_word, reg_val, offset);
      OP_SWR:  wdata = right_store(mem_word, reg_val, offset);
      default: wdata = lane_word;
    endcase
  end

endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl import ldm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_legal,
  output logic accept,
  output logic busy,
  output logic rd_phase,
  output logic mrg_phase,
  output logic fin_phase
);

  ldm_state_e state_q, state_d;

  assign accept    = req_valid && req_legal && (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rd_phase  = (state_q == ST_READ);
  assign mrg_phase = (state_q == ST_MERGE);
  assign fin_phase = (state_q == ST_FINISH);

  always_comb begin
    case (state_q)
      ST_IDLE:   state_d = accept ? ST_READ : ST_IDLE;
      ST_READ:   state_d = ST_MERGE;
      ST_MERGE:  state_d = ST_FINISH;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ldm_unit.sv
module ldm_unit import ldm_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5,
  localparam int BYTES    = DATA_W / 8,
  localparam int OFS_W    = $clog2(BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [3:0]           req_op,
  input  logic [DATA_W-1:0]    req_base,
  input  logic [IMM_W-1:0]     req_imm,
  input  logic [REG_IDX_W-1:0] req_rt_idx,
  input  logic [DATA_W-1:0]    req_rt_val,
  output logic                 busy,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [DATA_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [DATA_W-1:0]    wb_data,
  output logic                 done
);

  logic accept, busy_w, rd_phase, mrg_phase, fin_phase, legal_w;
  logic [DATA_W-1:0] ea_w, aligned_w, load_w, store_w;
  logic [OFS_W-1:0]  off_w;

  ldm_op_e              op_q;
  logic [DATA_W-1:0]    aligned_q, val_q, res_q;
  logic [OFS_W-1:0]     off_q;
  logic [REG_IDX_W-1:0] idx_q;
  logic                 wb_q;

  assign legal_w = op_is_legal(req_op);

  ldm_addr_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_addr (
    .base(req_base), .imm(req_imm),
    .eff_addr(ea_w), .aligned_addr(aligned_w), .offset(off_w)
  );

  ldm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(legal_w),
    .accept(accept), .busy(busy_w), .rd_phase(rd_phase),
    .mrg_phase(mrg_phase), .fin_phase(fin_phase)
  );

  ldm_load_align #(.DATA_W(DATA_W)) u_load (
    .op(op_q), .offset(off_q), .mem_word(mem_rdata), .reg_old(val_q), .result(load_w)
  );

  ldm_store_merge #(.DATA_W(DATA_W)) u_store (
    .op(op_q), .offset(off_q), .mem_word(mem_rdata), .reg_val(val_q), .wdata(store_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= OP_LB;
      aligned_q <= '0;
      off_q     <= '0;
      idx_q     <= '0;
      val_q     <= '0;
      res_q     <= '0;
      wb_q      <= 1'b0;
    end else begin
      if (accept) begin
        op_q      <= ldm_op_e'(req_op);
        aligned_q <= aligned_w;
        off_q     <= off_w;
        idx_q     <= req_rt_idx;
        val_q     <= req_rt_val;
      end
      if (mrg_phase) begin
        res_q <= load_w;
        wb_q  <= !op_is_store(op_q) && (idx_q != '0);
      end
    end
  end

  assign busy      = busy_w;
  assign mem_rd_en = rd_phase;
  assign mem_wr_en = mrg_phase && op_is_store(op_q);
  assign mem_addr  = aligned_q;
  assign mem_wdata = store_w;
  assign done      = fin_phase;
  assign wb_en     = fin_phase && wb_q;
  assign wb_idx    = idx_q;
  assign wb_data   = res_q;

endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 accept,
  input logic                 busy,
  input logic                 mem_rd_en,
  input logic                 mem_wr_en,
  input logic [DATA_W-1:0]    mem_addr,
  input logic                 wb_en,
  input logic [REG_IDX_W-1:0] wb_idx,
  input logic                 done
);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00)); // R1

  AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_rd_en && busy)); // R2

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_en, 2)); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_NO_ZERO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && wb_idx != '0)); // R9

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)); // R10

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R10

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !$past(mem_wr_en)); // R10

  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !accept) |=> (!busy && !mem_rd_en)); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R12

endmodule

bind ldm_unit ldm_checker #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_ldm_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .accept(accept), .busy(busy),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
  .wb_en(wb_en), .wb_idx(wb_idx), .done(done)
);

// File: tb/ldm_unit_bench.sv
module ldm_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [31:0] req_base;
  logic [15:0] req_imm;
  logic [4:0]  req_rt_idx;
  logic [31:0] req_rt_val;
  logic        busy, mem_rd_en, mem_wr_en, wb_en, done;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [4:0]  wb_idx;

  logic [31:0] mem_model [16];
  logic [31:0] rdata_q;
  int          rd_cnt, wr_cnt;
  logic [31:0] last_rd_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldm_unit u_ldm_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_imm(req_imm), .req_rt_idx(req_rt_idx),
    .req_rt_val(req_rt_val), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(rdata_q), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .done(done)
  );

  // word memory with one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem_model[i] <= 32'(32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0F0F;
      rdata_q      <= '0;
      rd_cnt       <= 0;
      wr_cnt       <= 0;
      last_rd_addr <= '0;
    end else begin
      if (mem_rd_en) begin
        rdata_q      <= mem_model[mem_addr[5:2]];
        rd_cnt       <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
      end
      if (mem_wr_en) begin
        mem_model[mem_addr[5:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'h2: return "R3 left load";
      4'h6: return "R4 right load";
      4'hA: return "R5 left store";
      4'hE: return "R6 right store";
      4'h0, 4'h1, 4'h4, 4'h5: return "R7 extend";
      default: return "R8 word/lane";
    endcase
  endfunction

  function automatic logic [31:0] exp_load(input logic [3:0] op, input logic [1:0] k,
                                           input logic [31:0] m, input logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    b = m[8*k +: 8];
    h = m[16*k[1] +: 16];
    case (op)
      4'h0: return {{24{b[7]}}, b};
      4'h4: return {24'h0, b};
      4'h1: return {{16{h[15]}}, h};
      4'h5: return {16'h0, h};
      4'h3: return m;
      4'h2: case (k)
              2'd0: return (m << 24) | (r & 32'h00FF_FFFF);
              2'd1: return (m << 16) | (r & 32'h0000_FFFF);
              2'd2: return (m << 8)  | (r & 32'h0000_00FF);
              default: return m;
            endcase
      default: case (k)
              2'd0: return m;
              2'd1: return (m >> 8)  | (r & 32'hFF00_0000);
              2'd2: return (m >> 16) | (r & 32'hFFFF_0000);
              default: return (m >> 24) | (r & 32'hFFFF_FF00);
            endcase
    endcase
  endfunction

  function automatic logic [31:0] exp_store(input logic [3:0] op, input logic [1:0] k,
                                            input logic [31:0] m, input logic [31:0] r);
    logic [31:0] t;
    t = m;
    case (op)
      4'h8: t[8*k +: 8] = r[7:0];
      4'h9: t[16*k[1] +: 16] = r[15:0];
      4'hB: t = r;
      4'hA: case (k)
              2'd0: t = (r >> 24) | (m & 32'hFFFF_FF00);
              2'd1: t = (r >> 16) | (m & 32'hFFFF_0000);
              2'd2: t = (r >> 8)  | (m & 32'hFF00_0000);
              default: t = r;
            endcase
      default: case (k)
              2'd0: t = r;
              2'd1: t = (r << 8)  | (m & 32'h0000_00FF);
              2'd2: t = (r << 16) | (m & 32'h0000_FFFF);
              default: t = (r << 24) | (m & 32'h00FF_FFFF);
            endcase
    endcase
    return t;
  endfunction

  // called at a falling edge while idle; returns at the falling edge after done
  task automatic run_op(input logic [3:0] op, input logic [31:0] base, input logic [15:0] imm,
                        input logic [4:0] idx, input logic [31:0] val);
    logic [31:0] ea, m_before, expv;
    int rd0, wr0, lat;
    string tag;
    tag      = op_tag(op);
    ea       = base + {{16{imm[15]}}, imm};
    m_before = mem_model[ea[5:2]];
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_op = op; req_base = base; req_imm = imm;
    req_rt_idx = idx; req_rt_val = val;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    check(lat == 3, "R2 done latency", 32'(lat), 32'd3);
    check(rd_cnt - rd0 == 1, "R2 single read", 32'(rd_cnt - rd0), 32'd1);
    check(last_rd_addr == {ea[31:2], 2'b00}, "R1 aligned address", last_rd_addr, {ea[31:2], 2'b00});
    if (op[3]) begin
      expv = exp_store(op, ea[1:0], m_before, val);
      check(wr_cnt - wr0 == 1, "R10 single write", 32'(wr_cnt - wr0), 32'd1);
      check(!wb_en, "R10 store no writeback", 32'(wb_en), 32'd0);
      check(mem_model[ea[5:2]] == expv, tag, mem_model[ea[5:2]], expv);
    end else begin
      expv = exp_load(op, ea[1:0], m_before, val);
      check(wr_cnt == wr0, "R10 load no write", 32'(wr_cnt - wr0), 32'd0);
      if (idx == 5'd0) begin
        check(!wb_en, "R9 zero destination", 32'(wb_en), 32'd0);
      end else begin
        check(wb_en && wb_idx == idx, "R9 writeback strobe", {26'h0, wb_en, wb_idx}, {26'h0, 1'b1, idx});
        check(wb_data == expv, tag, wb_data, expv);
      end
    end
    @(negedge clk);
    check(!done && !busy, "R2 single done pulse", {30'h0, done, busy}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] codes [12];
    logic [31:0] seed_sink;
    int rd0, wr0;
    logic [31:0] keep28;
    codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB, 4'hE};
    seed_sink = $urandom(32'h00C0_FFEE);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_base = '0; req_imm = '0;
    req_rt_idx = '0; req_rt_val = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(!busy && !mem_rd_en && !mem_wr_en && !wb_en && !done, "R13 reset outputs",
          {27'h0, busy, mem_rd_en, mem_wr_en, wb_en, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // left/right loads and stores at every offset
    for (int k = 0; k < 4; k++) begin
      run_op(4'hB, 32'h20, 16'h0, 5'd1, 32'h1122_3344);
      run_op(4'h2, 32'h20 + k, 16'h0, 5'd3, 32'hAABB_CCDD);
      run_op(4'h6, 32'h20 + k, 16'h0, 5'd4, 32'hAABB_CCDD);
      run_op(4'hA, 32'h20, 16'(k), 5'd2, 32'hAABB_CCDD);
      run_op(4'hB, 32'h20, 16'h0, 5'd1, 32'h1122_3344);
      run_op(4'hE, 32'h20, 16'(k), 5'd2, 32'hAABB_CCDD);
      run_op(4'h8, 32'h20 + k, 16'h0, 5'd2, 32'h0000_00E7);
      run_op(4'h9, 32'h20 + k, 16'h0, 5'd2, 32'h0000_9A5C);
    end
    // R7 extension with negative lanes
    run_op(4'hB, 32'h24, 16'h0, 5'd1, 32'h80FF_7F01);
    for (int k = 0; k < 4; k++) begin
      run_op(4'h0, 32'h24 + k, 16'h0, 5'd6, 32'h0);
      run_op(4'h4, 32'h24 + k, 16'h0, 5'd6, 32'h0);
      run_op(4'h1, 32'h24 + k, 16'h0, 5'd7, 32'h0);
      run_op(4'h5, 32'h24 + k, 16'h0, 5'd7, 32'h0);
    end
    // R9 zero destination still reads
    run_op(4'h3, 32'h24, 16'h0, 5'd0, 32'h0);
    run_op(4'h2, 32'h25, 16'h0, 5'd0, 32'h1234_5678);
    // R1 wraparound and negative displacement
    run_op(4'h3, 32'hFFFF_FFFE, 16'h0006, 5'd8, 32'h0);
    run_op(4'h6, 32'h0000_0010, 16'hFFF5, 5'd9, 32'hCAFE_F00D);

    // R11 illegal codes ignored
    foreach (codes[i]) begin end
    for (int c = 0; c < 4; c++) begin
      logic [3:0] bad;
      bad = (c == 0) ? 4'h7 : (c == 1) ? 4'hC : (c == 2) ? 4'hD : 4'hF;
      rd0 = rd_cnt; wr0 = wr_cnt;
      req_valid = 1'b1; req_op = bad; req_base = 32'h30; req_rt_idx = 5'd3;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) begin
        check(!busy && !done && !wb_en, "R11 illegal ignored", {29'h0, busy, done, wb_en}, 32'h0);
        @(negedge clk);
      end
      check(rd_cnt == rd0 && wr_cnt == wr0, "R11 no access", 32'(rd_cnt - rd0 + wr_cnt - wr0), 32'h0);
    end

    // R12 request while busy ignored
    keep28 = mem_model[4'hA];
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_op = 4'h3; req_base = 32'h20; req_imm = '0; req_rt_idx = 5'd5;
    @(negedge clk);
    req_op = 4'hB; req_base = 32'h28; req_rt_val = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(done, "R12 first request completes", 32'(done), 32'd1);
    repeat (2) @(negedge clk);
    check(rd_cnt - rd0 == 1 && wr_cnt == wr0, "R12 busy request ignored",
          32'(rd_cnt - rd0 + wr_cnt - wr0), 32'd1);
    check(mem_model[4'hA] == keep28, "R12 memory untouched", mem_model[4'hA], keep28);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      logic [31:0] base, val;
      logic [15:0] imm;
      logic [4:0] idx;
      op   = codes[$urandom_range(11)];
      base = $urandom;
      imm  = 16'($urandom);
      idx  = ($urandom_range(7) == 0) ? 5'd0 : 5'($urandom);
      val  = $urandom;
      run_op(op, base, imm, idx, val);
    end

    summary();
    $finish;
  end

endmodule